// File: doc/BRIEF.md
# Register Bit Poller with Microsecond Budget

This block waits for a byte-wide status register to reach a wanted state. A caller gives it a register address, a mask of bits that must read as one, a mask of bits that must read as zero, and a time budget in microseconds, then pulses `start`. The block reads the register through a bus-master read port. It stops at the first value that satisfies both masks, or when the budget is spent. It then pulses `done` and holds one of two result flags, `matched` or `timed_out`.

After each read that does not match, the block waits a fixed pause of `POLL_US` microseconds before it issues the next read. A clock divider of `CLK_PER_US` cycles turns clock cycles into microseconds, and this divider restarts at the beginning of every pause. The budget is counted in whole pauses: each read that does not match charges `POLL_US` microseconds. So a budget of T allows at most ceil(T / `POLL_US`) reads. The package also holds the usual budgets as constants: 750 ms for the access, expect and burst waits, and 2 s for the ready and response waits.

The read port is a pair of valid/ready channels. The request channel carries `req_addr`. The block raises `req_valid` and holds both `req_valid` and `req_addr` unchanged until it sees `req_ready` high on a rising edge. The bus may hold `req_ready` low for any number of cycles. The response channel carries `rsp_data`. The block raises `rsp_ready` only after its request has been accepted, and keeps it high until a beat with `rsp_valid` high is taken. Only one read is ever outstanding. The bus may delay `rsp_valid` for any number of cycles after the request is accepted.

Top module: `bitpoll_timeout`

## Requirements
- R1: A read value v matches when (v & set_mask) == set_mask and (v & clr_mask) == 0. Bits in neither mask are ignored. A match ends the poll with `matched`=1 and `timed_out`=0. The two flags are never high together.
- R2: `done` is high in the cycle after the response handshake of the matching read. After a match, no further request is issued.
- R3: After a read that does not match and leaves budget, `req_valid` rises again exactly `POLL_US`*`CLK_PER_US` cycles after that response handshake. This delay does not depend on `req_ready`.
- R4: Each read that does not match adds `POLL_US` to an elapsed count that starts at zero. Polling ends with `timed_out`=1 once the elapsed count is equal to or greater than the budget. With no match, exactly ceil(T/`POLL_US`) reads are made.
- R5: A budget of zero makes no read at all. `done` and `timed_out` are high in the cycle after `start` is accepted.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The address, masks and budget of the running poll stay unchanged.
- R7: `done` is high for exactly one cycle. `matched` and `timed_out` keep their values until the next accepted `start`, which clears both of them. `busy` is high from the cycle after an accepted `start` until `done`. When the budget is zero, `busy` stays low.
- R8: `req_valid` and `req_addr` stay unchanged until `req_ready` is seen. `rsp_ready` is high only while an accepted request is waiting for its response, so `req_valid` and `rsp_ready` are never high together.
- R9: After reset, `busy`, `done`, `matched`, `timed_out`, `req_valid` and `rsp_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll. Taken only when the block is idle |
| addr | input | ADDR_W | Address of the register to poll |
| set_mask | input | DATA_W | Bits that must read as one |
| clr_mask | input | DATA_W | Bits that must read as zero |
| timeout_us | input | TMO_W | Budget in microseconds |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | One-cycle pulse when a poll ends |
| matched | output | 1 | The last poll ended on a matching value |
| timed_out | output | 1 | The last poll ran out of budget |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Bus accepts the read request |
| req_addr | output | ADDR_W | Read request address |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Block accepts the read response |
| rsp_data | input | DATA_W | Read response data |

## Verification
The assertions assume the bus never returns `rsp_valid` unless a request has been accepted. They also assume that `start` is applied only with well-formed masks and budgets, since the block accepts any value. The stimulus keeps to this by modelling a bus with exactly one outstanding read. This model returns one response per accepted request, after a latency of zero to two cycles, and holds `req_ready` low for zero or one cycle on alternate runs. The stimulus pulses `start` during a poll only while `busy` is high, so that the pulse is meant to be ignored.

// File: rtl/bitpoll_pkg.sv
package bitpoll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2,
    ST_PAUSE = 2'd3
  } poll_state_e;

  // Customary wait budgets in microseconds
  localparam int BUDGET_ACCESS_US   = 750_000;
  localparam int BUDGET_READY_US    = 2_000_000;
  localparam int BUDGET_EXPECT_US   = 750_000;
  localparam int BUDGET_BURST_US    = 750_000;
  localparam int BUDGET_RESPONSE_US = 2_000_000;
endpackage

// File: rtl/bitpoll_match.sv
module bitpoll_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] must_set,
  input  logic [W-1:0] must_clear,
  output logic         hit
);
  logic ones_ok;
  logic zeros_ok;

  always_comb begin
    ones_ok  = ((value & must_set) == must_set);
    zeros_ok = ((value & must_clear) == '0);
    hit      = ones_ok && zeros_ok;
  end
endmodule

// File: rtl/bitpoll_ticker.sv
module bitpoll_ticker #(
  parameter int CLK_PER_US = 125,
  parameter int POLL_US    = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic interval_done
);
  localparam int UW = (POLL_US > 1) ? $clog2(POLL_US) : 1;

  logic          us_tick;
  logic [UW-1:0] us_q;

  generate
    if (CLK_PER_US == 1) begin : g_no_div
      assign us_tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLK_PER_US);
      logic [DW-1:0] div_q;
      assign us_tick = (div_q == DW'(CLK_PER_US - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run || us_tick) div_q <= '0;
        else                           div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  assign interval_done = run && us_tick && (us_q == UW'(POLL_US - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || interval_done) us_q <= '0;
    else if (us_tick)                     us_q <= us_q + 1'b1;
  end
endmodule

// File: rtl/bitpoll_budget.sv
module bitpoll_budget #(
  parameter int TMO_W = 22,
  parameter int STEP  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             charge,
  input  logic [TMO_W-1:0] limit,
  output logic             exhausted
);
  localparam int EW = TMO_W + 1;

  logic [EW-1:0] spent_q;
  logic [EW-1:0] spent_next;

  assign spent_next = spent_q + EW'(STEP);
  assign exhausted  = (spent_next >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || clear) spent_q <= '0;
    else if (charge)     spent_q <= spent_next;
  end
endmodule

// File: rtl/bitpoll_timeout.sv
module bitpoll_timeout
  import bitpoll_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int TMO_W      = 22,
  parameter int CLK_PER_US = 125,
  parameter int POLL_US    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [TMO_W-1:0]  timeout_us,
  output logic              busy,
  output logic              done,
  output logic              matched,
  output logic              timed_out,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data
);
  poll_state_e       st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] set_q;
  logic [DATA_W-1:0] clr_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              done_q;
  logic              matched_q;
  logic              tmo_flag_q;
  logic              hit;
  logic              exhausted;
  logic              pause_over;
  logic              take;
  logic              charge;

  assign take   = start && (st_q == ST_IDLE);
  assign charge = (st_q == ST_AWAIT) && rsp_valid && !hit;

  bitpoll_match #(.W(DATA_W)) u_match (
    .value      (rsp_data),
    .must_set   (set_q),
    .must_clear (clr_q),
    .hit        (hit)
  );

  bitpoll_budget #(.TMO_W(TMO_W), .STEP(POLL_US)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (take),
    .charge    (charge),
    .limit     (tmo_q),
    .exhausted (exhausted)
  );

  bitpoll_ticker #(.CLK_PER_US(CLK_PER_US), .POLL_US(POLL_US)) u_ticker (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (st_q == ST_PAUSE),
    .interval_done (pause_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      set_q      <= '0;
      clr_q      <= '0;
      tmo_q      <= '0;
      done_q     <= 1'b0;
      matched_q  <= 1'b0;
      tmo_flag_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            addr_q    <= addr;
            set_q     <= set_mask;
            clr_q     <= clr_mask;
            tmo_q     <= timeout_us;
            matched_q <= 1'b0;
            if (timeout_us == '0) begin
              done_q     <= 1'b1;
              tmo_flag_q <= 1'b1;
            end else begin
              tmo_flag_q <= 1'b0;
              st_q       <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: if (req_ready) st_q <= ST_AWAIT;
        ST_AWAIT: begin
          if (rsp_valid) begin
            if (hit) begin
              done_q    <= 1'b1;
              matched_q <= 1'b1;
              st_q      <= ST_IDLE;
            end else if (exhausted) begin
              done_q     <= 1'b1;
              tmo_flag_q <= 1'b1;
              st_q       <= ST_IDLE;
            end else begin
              st_q <= ST_PAUSE;
            end
          end
        end
        ST_PAUSE: if (pause_over) st_q <= ST_ISSUE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign matched   = matched_q;
  assign timed_out = tmo_flag_q;
  assign req_valid = (st_q == ST_ISSUE);
  assign req_addr  = addr_q;
  assign rsp_ready = (st_q == ST_AWAIT);
endmodule

// File: rtl/bitpoll_checker.sv
module bitpoll_checker #(
  parameter int ADDR_W = 16,
  parameter int TMO_W  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [TMO_W-1:0]  timeout_us,
  input logic              busy,
  input logic              done,
  input logic              matched,
  input logic              timed_out,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_ready
);
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(matched && timed_out));

  a_r2_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !req_valid && !rsp_ready));

  a_r5_zero_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && timeout_us == '0) |=> (done && timed_out && !busy));

  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(req_addr));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(matched) && $stable(timed_out)));

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));
endmodule

bind bitpoll_timeout bitpoll_checker #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .timeout_us (timeout_us),
  .busy       (busy),
  .done       (done),
  .matched    (matched),
  .timed_out  (timed_out),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_ready  (rsp_ready)
);

// File: tb/bitpoll_timeout_test.sv
module bitpoll_timeout_test;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int TW  = 6;
  localparam int CPU = 2;
  localparam int PU  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] set_mask = '0;
  logic [DW-1:0] clr_mask = '0;
  logic [TW-1:0] timeout_us = '0;
  logic busy, done, matched, timed_out, req_valid, rsp_ready;
  logic [AW-1:0] req_addr;
  logic req_ready = 1'b0;
  logic rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;

  always #4 clk = ~clk;

  bitpoll_timeout #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW), .CLK_PER_US(CPU), .POLL_US(PU)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .set_mask(set_mask),
    .clr_mask(clr_mask), .timeout_us(timeout_us), .busy(busy), .done(done),
    .matched(matched), .timed_out(timed_out), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // run configuration, written by the main process only
  int cur_hit = 0, cur_lat = 0, cur_stall = 0, run_base = 0;
  bit cur_fixed = 1'b0;
  logic [DW-1:0] cur_fv = '0;
  logic [AW-1:0] cur_addr = '0;

  // responder state and its own counters
  int rd_total = 0, lat_cnt = 0, stall_cnt = 0, hs_cyc = 0, r_checks = 0, r_fails = 0;
  bit pend = 1'b0, rv_prev = 1'b0;

  // read i: 8'h91 meets set 8'h81 / clear 8'h24; 8'h11 lacks bit7; 8'h95 has bit2
  function automatic logic [DW-1:0] seq_val(input int i);
    if (cur_fixed)    return cur_fv;
    if (i == cur_hit) return 8'h91;
    return (i % 2 == 1) ? 8'h95 : 8'h11;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin rsp_valid = 1'b0; pend = 1'b0; end
      if (req_ready) req_ready = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = seq_val(rd_total - run_base - 1);
        end
      end
      if (rsp_valid && !pend && rsp_ready) begin pend = 1'b1; hs_cyc = cyc + 1; end
      if (req_valid && !rv_prev && rd_total != run_base) begin
        r_checks++;
        if (cyc - hs_cyc != PU * CPU) begin
          r_fails++;
          $display("FAIL R3 pause length actual=%0d expected=%0d", cyc - hs_cyc, PU * CPU);
        end
      end
      rv_prev = req_valid;
      if (req_valid && !req_ready) begin
        if (stall_cnt > 0) stall_cnt--;
        else begin
          req_ready = 1'b1;
          rd_total++;
          stall_cnt = cur_stall;
          lat_cnt   = cur_lat + 1;
          r_checks++;
          if (req_addr !== cur_addr) begin
            r_fails++;
            $display("FAIL R6 read address actual=%0h expected=%0h", req_addr, cur_addr);
          end
        end
      end
    end
  end

  int n_checks = 0, n_fails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_poll(input logic [AW-1:0] a, input logic [DW-1:0] s, input logic [DW-1:0] c,
                          input int t, input int hit, input int lat, input int stall,
                          input bit fixed, input logic [DW-1:0] fv, input bit poke);
    int base, nmax, exp_reads, wait_n, m_exp, t_exp;
    cur_hit = hit; cur_lat = lat; cur_stall = stall; cur_fixed = fixed; cur_fv = fv; cur_addr = a;
    base = rd_total; run_base = base;
    nmax = (t + PU - 1) / PU;
    if (hit < nmax) begin exp_reads = hit + 1; m_exp = 1; t_exp = 0; end
    else            begin exp_reads = nmax;    m_exp = 0; t_exp = 1; end
    @(negedge clk);
    start = 1'b1; addr = a; set_mask = s; clr_mask = c; timeout_us = TW'(t);
    @(negedge clk);
    start = 1'b0; addr = ~a; set_mask = ~s; clr_mask = ~c; timeout_us = '0;
    if (t == 0) begin
      check(done && timed_out && !matched && !busy, "R5 zero budget done/timed_out", {done, timed_out}, 2'b11);
    end else begin
      check(busy && !matched && !timed_out, "R7 start clears result, sets busy", {busy, matched, timed_out}, 3'b100);
    end
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      if (poke && wait_n == 1) begin
        check(busy == 1'b1, "R6 busy when poked", busy, 1);
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      wait_n++;
    end
    check(done == 1'b1, "R2 done seen", done, 1);
    check(matched == m_exp[0], "R1 matched flag", matched, m_exp);
    check(timed_out == t_exp[0], "R4 timed_out flag", timed_out, t_exp);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    check(rd_total - base == exp_reads, (m_exp == 1) ? "R2 reads after match" : "R4 read count",
          rd_total - base, exp_reads);
    check(matched == m_exp[0] && timed_out == t_exp[0], "R7 result held",
          {matched, timed_out}, {m_exp[0], t_exp[0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !matched && !timed_out && !req_valid && !rsp_ready, "R9 reset state",
          {busy, done, matched, timed_out, req_valid, rsp_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !req_valid && !rsp_ready, "R9 idle after reset",
          {busy, done, req_valid, rsp_ready}, 0);

    // R4 R2 R3 R6: budget sweep against match position
    for (int t = 0; t < 14; t++) begin
      for (int h = 0; h < 6; h++) begin
        run_poll(AW'(t * 17 + h * 5), 8'h81, 8'h24, t, (h == 5) ? 99 : h, t % 3, h % 2,
                 1'b0, 8'h00, (t > 0) && (h % 2 == 0));
      end
    end
    // R4 boundaries: largest budget, never matching
    run_poll(8'h5A, 8'h81, 8'h24, (1 << TW) - 1, 99, 1, 0, 1'b0, 8'h00, 1'b0);
    run_poll(8'hA5, 8'h81, 8'h24, PU, 99, 0, 1, 1'b0, 8'h00, 1'b1);
    run_poll(8'h3C, 8'h81, 8'h24, PU + 1, 1, 0, 0, 1'b0, 8'h00, 1'b0);

    // R1: every mask/value combination on three bits, one read each
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int v = 0; v < 8; v++) begin
          logic [DW-1:0] vv;
          bit ok;
          vv = {5'b10110, 3'(v)};
          ok = ((vv & DW'(s)) == DW'(s)) && ((vv & DW'(c)) == '0);
          run_poll(AW'(s * 64 + c * 8 + v), DW'(s), DW'(c), PU, ok ? 0 : 1000, v % 2, 0,
                   1'b1, vv, 1'b0);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks + r_checks, n_fails + r_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks + r_checks + 1, n_fails + r_fails + 1);
    $finish;
  end
endmodule